// File: doc/BRIEF.md
# Two-Channel Interrupt Priority Arbiter

This block merges the interrupt requests of two independent serial channels into a vectored host interrupt interface. Each channel raises a level request and supplies its own 8-bit vector. The arbiter grants one channel at a time and shows the grant on one of two request lines toward the carrier. It then waits for the host's acknowledge strobe and returns the vector of the granted channel with a one-cycle valid strobe.

Channel A wins only when both channels compete for an idle arbiter. Once a channel holds the grant, a later request from the other channel waits until the current grant is acknowledged or withdrawn. After an acknowledge, a channel that keeps requesting steps aside for one arbitration if the other channel was waiting. This stops either channel from starving the other.

Top module: `irq_pair_arbiter`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `irq_o` is 2'b00, `vec_vld_o` is 0 and `vec_o` is 0x00.
- R2: A grant to channel A drives `irq_o` = 2'b01 and a grant to channel B drives `irq_o` = 2'b10. At most one bit is ever high. From idle, a request sampled at a clock edge shows on `irq_o` after that same edge.
- R3: When both requests are sampled together by an idle arbiter that has no deferral pending, channel A is granted.
- R4: While channel B holds the grant and keeps requesting, a request from channel A does not change `irq_o` until channel B's grant is acknowledged.
- R5: An acknowledge sampled while a channel holds the grant makes `vec_vld_o` high for exactly the next cycle. In that cycle `vec_o[7:0]` carries the granted channel's vector as it was at the acknowledge edge, and `irq_o` reads 2'b00.
- R6: If the other channel was requesting when a grant was acknowledged, the other channel is granted at the next arbitration, even if the acknowledged channel still requests. Later ties again go to channel A.
- R7: If the granted channel drops its request before an acknowledge, `irq_o` returns to 2'b00 after the next edge and no vector strobe is issued.
- R8: An acknowledge sampled while no grant is held returns `vec_o` = 0xFF with `vec_vld_o` high for one cycle.
- R9: If an acknowledge and the withdrawal of the granted request occur in the same cycle, the acknowledge wins and the vector is returned.
- R10: `vec_o` keeps its last value while `vec_vld_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_a_i | input | 1 | Channel A level interrupt request |
| req_b_i | input | 1 | Channel B level interrupt request |
| vec_a_i | input | 8 | Channel A interrupt vector |
| vec_b_i | input | 8 | Channel B interrupt vector |
| ack_i | input | 1 | Host acknowledge strobe, one cycle |
| irq_o | output | 2 | Request lines to the carrier: bit 0 channel A, bit 1 channel B |
| vec_o | output | 8 | Returned vector |
| vec_vld_o | output | 1 | One-cycle strobe marking `vec_o` valid |

## Verification
The deferral after an acknowledge is the hardest state to reach from the ports. It needs both channels requesting, then an acknowledge of one of them while the other still waits, with the acknowledged channel keeping its request up. The directed sequence builds this state from a tie and checks that the grant changes hands. It then acknowledges the second channel with both requests still up and checks that the priority of channel A comes back. A long stretch of random requests, vectors and acknowledges is then compared every clock against a behavioural model. This covers same-cycle acknowledge and withdrawal, and spurious acknowledges.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  typedef enum logic [1:0] {
    GNT_NONE = 2'd0,
    GNT_A    = 2'd1,
    GNT_B    = 2'd2
  } gnt_e;
endpackage

// File: rtl/irq_arb_pick.sv
module irq_arb_pick
  import irq_arb_pkg::*;
(
  input  logic req_a_i,
  input  logic req_b_i,
  input  gnt_e defer_i,
  output gnt_e pick_o
);
  always_comb begin
    if (req_a_i && req_b_i)
      pick_o = (defer_i == GNT_A) ? GNT_B : GNT_A;
    else if (req_a_i)
      pick_o = GNT_A;
    else if (req_b_i)
      pick_o = GNT_B;
    else
      pick_o = GNT_NONE;
  end
endmodule

// File: rtl/irq_arb_vecret.sv
module irq_arb_vecret
  import irq_arb_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ack_i,
  input  gnt_e             gnt_i,
  input  logic [VEC_W-1:0] vec_a_i,
  input  logic [VEC_W-1:0] vec_b_i,
  output logic [VEC_W-1:0] vec_o,
  output logic             vld_o
);
  localparam logic [VEC_W-1:0] SPUR_VEC = '1;

  logic [VEC_W-1:0] vec_sel;

  always_comb begin
    unique case (gnt_i)
      GNT_A:   vec_sel = vec_a_i;
      GNT_B:   vec_sel = vec_b_i;
      default: vec_sel = SPUR_VEC;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_o <= '0;
      vld_o <= 1'b0;
    end else begin
      vld_o <= ack_i;
      if (ack_i) vec_o <= vec_sel;
    end
  end

  // R10
  vec_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_i |=> $stable(vec_o));
endmodule

// File: rtl/irq_pair_arbiter.sv
module irq_pair_arbiter
  import irq_arb_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_a_i,
  input  logic             req_b_i,
  input  logic [VEC_W-1:0] vec_a_i,
  input  logic [VEC_W-1:0] vec_b_i,
  input  logic             ack_i,
  output logic [1:0]       irq_o,
  output logic [VEC_W-1:0] vec_o,
  output logic             vec_vld_o
);
  localparam logic [VEC_W-1:0] SPUR_VEC = '1;

  gnt_e gnt_q, gnt_d;
  gnt_e defer_q, defer_d;
  gnt_e pick;

  irq_arb_pick u_pick (
    .req_a_i (req_a_i),
    .req_b_i (req_b_i),
    .defer_i (defer_q),
    .pick_o  (pick)
  );

  irq_arb_vecret #(.VEC_W(VEC_W)) u_vecret (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ack_i   (ack_i),
    .gnt_i   (gnt_q),
    .vec_a_i (vec_a_i),
    .vec_b_i (vec_b_i),
    .vec_o   (vec_o),
    .vld_o   (vec_vld_o)
  );

  // grant moves only on ack of holder, withdrawal, or from idle
  always_comb begin
    gnt_d   = gnt_q;
    defer_d = defer_q;
    unique case (gnt_q)
      GNT_A: begin
        if (ack_i) begin
          gnt_d   = GNT_NONE;
          defer_d = req_b_i ? GNT_A : GNT_NONE;
        end else if (!req_a_i) begin
          gnt_d = GNT_NONE;
        end
      end
      GNT_B: begin
        if (ack_i) begin
          gnt_d   = GNT_NONE;
          defer_d = req_a_i ? GNT_B : GNT_NONE;
        end else if (!req_b_i) begin
          gnt_d = GNT_NONE;
        end
      end
      default: begin
        gnt_d = pick;
        if (pick != GNT_NONE) defer_d = GNT_NONE;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gnt_q   <= GNT_NONE;
      defer_q <= GNT_NONE;
    end else begin
      gnt_q   <= gnt_d;
      defer_q <= defer_d;
    end
  end

  assign irq_o = {gnt_q == GNT_B, gnt_q == GNT_A};

  // R2
  irq_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(irq_o));

  // R3
  tie_a_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o == 2'b00 && req_a_i && req_b_i && defer_q != GNT_A) |=> irq_o == 2'b01);

  // R4
  no_preempt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o[1] && req_b_i && !ack_i) |=> (irq_o == 2'b10));

  // R5
  vld_from_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_vld_o |-> $past(ack_i));

  // R5
  ack_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && irq_o != 2'b00) |=> (irq_o == 2'b00 && vec_vld_o));

  // R7
  withdraw_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o[0] && !req_a_i && !ack_i) |=> (!irq_o[0] && !vec_vld_o));

  // R8
  spurious_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && irq_o == 2'b00) |=> (vec_vld_o && vec_o == SPUR_VEC));
endmodule

// File: tb/irq_pair_arbiter_test.sv
module irq_pair_arbiter_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_a = 1'b0, req_b = 1'b0, ack = 1'b0;
  logic [7:0] va = 8'h00, vb = 8'h00;
  logic [1:0] irq;
  logic [7:0] vec;
  logic       vld;

  int checks = 0;
  int failures = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  // behavioural reference: 0 idle, 1 A, 2 B
  int         m_gnt = 0;
  int         m_def = 0;
  logic [7:0] m_vec = 8'h00;
  logic       m_vld = 1'b0;

  always #2 clk = ~clk;

  irq_pair_arbiter uut (
    .clk_i(clk), .rst_ni(rst_n), .req_a_i(req_a), .req_b_i(req_b),
    .vec_a_i(va), .vec_b_i(vb), .ack_i(ack),
    .irq_o(irq), .vec_o(vec), .vec_vld_o(vld)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_gnt = 0; m_def = 0; m_vec = 8'h00; m_vld = 1'b0;
    end else begin
      m_vld = ack;
      if (ack) m_vec = (m_gnt == 1) ? va : (m_gnt == 2) ? vb : 8'hFF;
      if (m_gnt == 1) begin
        if (ack) begin m_def = req_b ? 1 : 0; m_gnt = 0; end
        else if (!req_a) m_gnt = 0;
      end else if (m_gnt == 2) begin
        if (ack) begin m_def = req_a ? 2 : 0; m_gnt = 0; end
        else if (!req_b) m_gnt = 0;
      end else begin
        if (req_a && req_b) m_gnt = (m_def == 1) ? 2 : 1;
        else if (req_a) m_gnt = 1;
        else if (req_b) m_gnt = 2;
        if (m_gnt != 0) m_def = 0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    logic [1:0] exp_irq;
    @(negedge clk);
    exp_irq = (m_gnt == 1) ? 2'b01 : (m_gnt == 2) ? 2'b10 : 2'b00;
    chk(irq == exp_irq, cur_req, irq, exp_irq);
    chk(vld == m_vld, cur_req, vld, m_vld);
    chk(vec == m_vec, cur_req, vec, m_vec);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk(irq == 2'b00 && vld == 1'b0 && vec == 8'h00, "R1", {irq, vld, vec}, 0);
    rst_n = 1'b1;
    tick();
    chk(irq == 2'b00 && vld == 1'b0, "R1", {irq, vld}, 0);

    // R2 channel A alone, R5 vector return
    cur_req = "R2"; va = 8'h3C; vb = 8'hA5;
    req_a = 1'b1; tick();
    chk(irq == 2'b01, "R2", irq, 2'b01);
    cur_req = "R5"; ack = 1'b1; tick(); ack = 1'b0; req_a = 1'b0;
    chk(vld && vec == 8'h3C && irq == 2'b00, "R5", vec, 8'h3C);
    tick();
    chk(vld == 1'b0 && vec == 8'h3C, "R10", {vld, vec}, 8'h3C);

    // R2 channel B alone
    cur_req = "R2"; req_b = 1'b1; tick();
    chk(irq == 2'b10, "R2", irq, 2'b10);
    ack = 1'b1; tick(); ack = 1'b0; req_b = 1'b0;
    chk(vld && vec == 8'hA5, "R5", vec, 8'hA5);
    tick();

    // R3 tie, then R6 deferral of a still-requesting channel
    cur_req = "R3"; req_a = 1'b1; req_b = 1'b1; tick();
    chk(irq == 2'b01, "R3", irq, 2'b01);
    cur_req = "R6"; ack = 1'b1; tick(); ack = 1'b0;
    chk(vld && vec == 8'h3C, "R6", vec, 8'h3C);
    tick();
    chk(irq == 2'b10, "R6", irq, 2'b10);
    vb = 8'h5A; ack = 1'b1; tick(); ack = 1'b0;
    chk(vld && vec == 8'h5A, "R6", vec, 8'h5A);
    tick();
    chk(irq == 2'b01, "R6", irq, 2'b01);
    ack = 1'b1; tick(); ack = 1'b0; req_a = 1'b0; req_b = 1'b0;
    tick(); tick();

    // R4 B pending blocks A
    cur_req = "R4"; req_b = 1'b1; tick();
    req_a = 1'b1; tick(); tick(); tick();
    chk(irq == 2'b10, "R4", irq, 2'b10);
    ack = 1'b1; tick(); ack = 1'b0; req_b = 1'b0;
    chk(vld && vec == 8'h5A, "R4", vec, 8'h5A);
    tick();
    chk(irq == 2'b01, "R4", irq, 2'b01);

    // R7 withdrawal before ack
    cur_req = "R7"; req_a = 1'b0; tick();
    chk(irq == 2'b00 && vld == 1'b0, "R7", {irq, vld}, 0);
    tick();
    chk(vld == 1'b0, "R7", vld, 0);

    // R8 spurious ack
    cur_req = "R8"; ack = 1'b1; tick(); ack = 1'b0;
    chk(vld && vec == 8'hFF, "R8", vec, 8'hFF);
    tick();

    // R9 ack together with withdrawal
    cur_req = "R9"; va = 8'h81; req_a = 1'b1; tick();
    ack = 1'b1; req_a = 1'b0; tick(); ack = 1'b0;
    chk(vld && vec == 8'h81 && irq == 2'b00, "R9", vec, 8'h81);
    tick();

    // random traffic against the reference model
    cur_req = "R2";
    for (int i = 0; i < 3000; i++) begin
      req_a = ($urandom % 4) != 0 ? req_a : ~req_a;
      req_b = ($urandom % 4) != 0 ? req_b : ~req_b;
      ack   = ($urandom % 5) == 0;
      va    = 8'($urandom);
      vb    = 8'($urandom);
      tick();
    end
    ack = 1'b0; req_a = 1'b0; req_b = 1'b0;
    tick(); tick();
    finish_run();
  end
endmodule